// File: doc/BRIEF.md
# Masked Burst Address Counter

This block generates the address for one port of a synchronous memory. A controller loads a start address from the external address bus, and the block then steps that address one location per burst cycle with no further address traffic. A mask register chooses which address bits take part in counting. Bits outside the mask keep the value they were loaded with, so the mask fixes the size and alignment of the block that a burst circles through.

When every counting bit is 1 and another increment arrives, the counting bits return to zero and a sticky wrap flag is raised. A retransmit command moves the counter back to the first location of the block that holds the last loaded address, so a block can be sent again without reloading it. The controller can read the counter and the mask back over a registered readback bus. An asynchronous active-low master reset puts the counter, mask and flag in a known state. Its release is synchronised to the clock.

Top module: `burst_addr_gen`

## Requirements
- R1: While the master reset `rst_n` is low, and once it has been released, until the first command: `mem_addr_o` is 0, `wrap_irq_o` is 0, `rdbk_vld_o` is 0 and the mask is all ones. Commands applied while reset is held have no effect.
- R2: Command code 1 (load address) makes `mem_addr_o` equal `addr_i` on the next cycle, clears `wrap_irq_o` and records the address as the retransmit base.
- R3: Command code 2 (increment) adds one to the counter, counting only the bits whose mask bit is 1. The carry passes over bits whose mask bit is 0, and those bits keep their value.
- R4: An increment issued while all counting bits are 1 clears those bits, keeps the other bits, and sets `wrap_irq_o` on the next cycle.
- R5: Once `wrap_irq_o` is set it stays set until a load address (1) or retransmit (4) command.
- R6: Command code 4 (retransmit) sets the counter to the last loaded address with its counting bits cleared, and clears `wrap_irq_o`.
- R7: Command code 3 (load mask) copies `addr_i` into the mask without moving the counter. No other command changes the mask.
- R8: Command code 5 (read counter) presents the counter value on `rdbk_o` with `rdbk_vld_o` high for exactly the next cycle, and the counter holds. `rdbk_o` is 0 whenever `rdbk_vld_o` is low.
- R9: Command code 6 (read mask) presents the mask value on `rdbk_o` with `rdbk_vld_o` high for exactly the next cycle.
- R10: Command code 0 (hold) and the unused code 7 leave the counter, mask and flag unchanged.
- R11: With a mask of zero, an increment leaves the counter unchanged and sets `wrap_irq_o`, because every increment is a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| op_i | input | 3 | Command code, one per cycle |
| addr_i | input | ADDR_W | External address or mask value |
| mem_addr_o | output | ADDR_W | Current counter value, drives the memory address |
| rdbk_o | output | ADDR_W | Readback data (counter or mask) |
| rdbk_vld_o | output | 1 | Readback data valid |
| wrap_irq_o | output | 1 | Sticky wrap flag |

## Verification
The bench builds the block with an 8-bit address and a two-stage reset synchroniser. With 8 bits, a full-width wrap from 0xFF to 0x00 takes only a few commands, and so do wraps inside 2-bit blocks. The narrow width also makes it practical to use a non-contiguous mask (bits 0 and 2) to show the carry passing over held bits. The short synchroniser lets the bench check, within a few cycles, that commands are ignored while reset is held.

// File: rtl/bac_pkg.sv
package bac_pkg;

  typedef enum logic [2:0] {
    OP_HOLD   = 3'd0,
    OP_LOAD   = 3'd1,
    OP_INCR   = 3'd2,
    OP_LDMASK = 3'd3,
    OP_RETX   = 3'd4,
    OP_RDCNT  = 3'd5,
    OP_RDMASK = 3'd6,
    OP_SPARE  = 3'd7
  } bac_op_e;

  localparam int unsigned BAC_MIN_SYNC = 2;

endpackage

// File: rtl/bac_rst_sync.sv
module bac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= {sr_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sr_q[STAGES-1];

endmodule

// File: rtl/bac_mask_incr.sv
// Increment restricted to masked bits; carry ripples past unmasked bits.
module bac_mask_incr #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] mask,
  output logic [W-1:0] nxt,
  output logic         wrap
);

  logic [W:0] carry;

  assign carry[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign nxt[i]     = mask[i] ? (cnt[i] ^ carry[i]) : cnt[i];
    assign carry[i+1] = mask[i] ? (cnt[i] & carry[i]) : carry[i];
  end

  assign wrap = carry[W];

endmodule

// File: rtl/bac_readback.sv
module bac_readback #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_cnt,
  input  logic         sel_mask,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] mask,
  output logic [W-1:0] data_o,
  output logic         vld_o
);

  logic [W-1:0] data_d;
  logic         vld_d;

  always_comb begin
    vld_d  = sel_cnt | sel_mask;
    data_d = '0;
    if (sel_cnt) begin
      data_d = cnt;
    end else if (sel_mask) begin
      data_d = mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      data_o <= data_d;
      vld_o  <= vld_d;
    end
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bac_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] rdbk_o,
  output logic              rdbk_vld_o,
  output logic              wrap_irq_o
);

  localparam int STG = (SYNC_STAGES < BAC_MIN_SYNC) ? BAC_MIN_SYNC : SYNC_STAGES;

  logic              rst_sync_n;
  bac_op_e           op;
  logic [ADDR_W-1:0] cnt_q, cnt_d, mask_q, mask_d, base_q, base_d;
  logic              irq_q, irq_d;
  logic              cnt_en, mask_en, base_en, irq_en;
  logic [ADDR_W-1:0] incr_val;
  logic              incr_wrap;

  assign op = bac_op_e'(op_i);

  bac_rst_sync #(.STAGES(STG)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bac_mask_incr #(.W(ADDR_W)) u_incr (
    .cnt  (cnt_q),
    .mask (mask_q),
    .nxt  (incr_val),
    .wrap (incr_wrap)
  );

  // next-state
  always_comb begin
    cnt_d   = cnt_q;
    mask_d  = mask_q;
    base_d  = base_q;
    irq_d   = irq_q;
    cnt_en  = 1'b0;
    mask_en = 1'b0;
    base_en = 1'b0;
    irq_en  = 1'b0;
    case (op)
      OP_LOAD: begin
        cnt_d   = addr_i;
        base_d  = addr_i;
        irq_d   = 1'b0;
        cnt_en  = 1'b1;
        base_en = 1'b1;
        irq_en  = 1'b1;
      end
      OP_INCR: begin
        cnt_d  = incr_val;
        cnt_en = 1'b1;
        if (incr_wrap) begin
          irq_d  = 1'b1;
          irq_en = 1'b1;
        end
      end
      OP_LDMASK: begin
        mask_d  = addr_i;
        mask_en = 1'b1;
      end
      OP_RETX: begin
        cnt_d  = base_q & ~mask_q;
        irq_d  = 1'b0;
        cnt_en = 1'b1;
        irq_en = 1'b1;
      end
      default: begin
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q  <= '0;
      mask_q <= '1;
      base_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (mask_en) mask_q <= mask_d;
      if (base_en) base_q <= base_d;
      if (irq_en)  irq_q  <= irq_d;
    end
  end

  bac_readback #(.W(ADDR_W)) u_rdbk (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sel_cnt  (op == OP_RDCNT),
    .sel_mask (op == OP_RDMASK),
    .cnt      (cnt_q),
    .mask     (mask_q),
    .data_o   (rdbk_o),
    .vld_o    (rdbk_vld_o)
  );

  assign mem_addr_o = cnt_q;
  assign wrap_irq_o = irq_q;

endmodule

// File: rtl/bac_chk.sv
module bac_chk
  import bac_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         srst_n,
  input logic [2:0]   op,
  input logic [W-1:0] addr,
  input logic [W-1:0] cnt,
  input logic [W-1:0] mask,
  input logic         irq,
  input logic [W-1:0] rdbk,
  input logic         rdbk_vld
);

  p_load_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (op == OP_LOAD) |=> (cnt == $past(addr)) && !irq);

  p_incr_keep_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (op == OP_INCR) |=> ((cnt & ~mask) == ($past(cnt) & ~mask)));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (op == OP_INCR && (cnt & mask) == mask) |=> irq && ((cnt & mask) == '0));

  p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (irq && op != OP_LOAD && op != OP_RETX) |=> irq);

  p_retx_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (op == OP_RETX) |=> ((cnt & mask) == '0) && !irq);

  p_mask_only_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (op != OP_LDMASK) |=> $stable(mask));

  p_rdcnt_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (op == OP_RDCNT) |=> rdbk_vld && (rdbk == $past(cnt)) && $stable(cnt));

  p_rdmask_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (op == OP_RDMASK) |=> rdbk_vld && (rdbk == $past(mask)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (op == OP_HOLD || op == OP_SPARE) |=> $stable(cnt) && $stable(irq));

  p_zero_mask_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (op == OP_INCR && mask == '0) |=> $stable(cnt) && irq);

endmodule

bind burst_addr_gen bac_chk #(.W(ADDR_W)) u_chk (
  .clk      (clk),
  .srst_n   (rst_sync_n),
  .op       (op_i),
  .addr     (addr_i),
  .cnt      (cnt_q),
  .mask     (mask_q),
  .irq      (irq_q),
  .rdbk     (rdbk_o),
  .rdbk_vld (rdbk_vld_o)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int NV = 30;

  logic         clk;
  logic         rst_n;
  logic [2:0]   op_i;
  logic [W-1:0] addr_i;
  logic [W-1:0] mem_addr_o;
  logic [W-1:0] rdbk_o;
  logic         rdbk_vld_o;
  logic         wrap_irq_o;

  int checks = 0;
  int errors = 0;

  burst_addr_gen #(.ADDR_W(W), .SYNC_STAGES(2)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op_i),
    .addr_i     (addr_i),
    .mem_addr_o (mem_addr_o),
    .rdbk_o     (rdbk_o),
    .rdbk_vld_o (rdbk_vld_o),
    .wrap_irq_o (wrap_irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {req[32:29], op[28:26], addr[25:18], cnt[17:10], irq[9], vld[8], rdbk[7:0]}
  localparam logic [32:0] VEC [NV] = '{
    {4'd9,  3'd6, 8'h00, 8'h00, 1'b0, 1'b1, 8'hFF}, // R9 / R1 reset mask all ones
    {4'd8,  3'd5, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00}, // R8 / R1 reset counter
    {4'd7,  3'd3, 8'h03, 8'h00, 1'b0, 1'b0, 8'h00}, // R7 mask 0x03, R8 valid drops
    {4'd2,  3'd1, 8'hA5, 8'hA5, 1'b0, 1'b0, 8'h00}, // R2
    {4'd3,  3'd2, 8'h00, 8'hA6, 1'b0, 1'b0, 8'h00}, // R3
    {4'd3,  3'd2, 8'h00, 8'hA7, 1'b0, 1'b0, 8'h00}, // R3
    {4'd4,  3'd2, 8'h00, 8'hA4, 1'b1, 1'b0, 8'h00}, // R4 wrap keeps upper bits
    {4'd5,  3'd2, 8'h00, 8'hA5, 1'b1, 1'b0, 8'h00}, // R5 flag sticky
    {4'd10, 3'd0, 8'h00, 8'hA5, 1'b1, 1'b0, 8'h00}, // R10 hold
    {4'd10, 3'd7, 8'h33, 8'hA5, 1'b1, 1'b0, 8'h00}, // R10 spare code
    {4'd8,  3'd5, 8'h00, 8'hA5, 1'b1, 1'b1, 8'hA5}, // R8 counter holds
    {4'd6,  3'd4, 8'h00, 8'hA4, 1'b0, 1'b0, 8'h00}, // R6 retransmit
    {4'd3,  3'd2, 8'h00, 8'hA5, 1'b0, 1'b0, 8'h00}, // R3
    {4'd7,  3'd3, 8'h0C, 8'hA5, 1'b0, 1'b0, 8'h00}, // R7 counter not moved
    {4'd3,  3'd2, 8'h00, 8'hA9, 1'b0, 1'b0, 8'h00}, // R3 bits 3:2 count
    {4'd3,  3'd2, 8'h00, 8'hAD, 1'b0, 1'b0, 8'h00}, // R3
    {4'd4,  3'd2, 8'h00, 8'hA1, 1'b1, 1'b0, 8'h00}, // R4
    {4'd6,  3'd4, 8'h00, 8'hA1, 1'b0, 1'b0, 8'h00}, // R6 base 0xA5 & ~0x0C
    {4'd7,  3'd3, 8'h05, 8'hA1, 1'b0, 1'b0, 8'h00}, // R7 non-contiguous mask
    {4'd3,  3'd2, 8'h00, 8'hA4, 1'b0, 1'b0, 8'h00}, // R3 carry passes bit 1
    {4'd3,  3'd2, 8'h00, 8'hA5, 1'b0, 1'b0, 8'h00}, // R3
    {4'd4,  3'd2, 8'h00, 8'hA0, 1'b1, 1'b0, 8'h00}, // R4
    {4'd2,  3'd1, 8'h3C, 8'h3C, 1'b0, 1'b0, 8'h00}, // R2 load clears flag
    {4'd7,  3'd3, 8'h00, 8'h3C, 1'b0, 1'b0, 8'h00}, // R7 zero mask
    {4'd11, 3'd2, 8'h00, 8'h3C, 1'b1, 1'b0, 8'h00}, // R11
    {4'd9,  3'd6, 8'h00, 8'h3C, 1'b1, 1'b1, 8'h00}, // R9
    {4'd7,  3'd3, 8'hFF, 8'h3C, 1'b1, 1'b0, 8'h00}, // R7
    {4'd2,  3'd1, 8'hFE, 8'hFE, 1'b0, 1'b0, 8'h00}, // R2
    {4'd3,  3'd2, 8'h00, 8'hFF, 1'b0, 1'b0, 8'h00}, // R3
    {4'd4,  3'd2, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00}  // R4 full-width wrap
  };

  task automatic chk(input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_outs(input int req, input logic [W-1:0] c, input logic irq,
                          input logic vld, input logic [W-1:0] rb);
    chk(req, "mem_addr_o", 32'(mem_addr_o), 32'(c));
    chk(req, "wrap_irq_o", 32'(wrap_irq_o), 32'(irq));
    chk(req, "rdbk_vld_o", 32'(rdbk_vld_o), 32'(vld));
    chk(req, "rdbk_o",     32'(rdbk_o),     32'(rb));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    op_i   = 3'd1;
    addr_i = 8'h5A;
    repeat (3) @(negedge clk);
    // R1: load held off while reset is low
    chk_outs(1, 8'h00, 1'b0, 1'b0, 8'h00);
    op_i = 3'd0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_outs(1, 8'h00, 1'b0, 1'b0, 8'h00);

    for (int i = 0; i < NV; i++) begin
      op_i   = VEC[i][28:26];
      addr_i = VEC[i][25:18];
      @(negedge clk);
      chk_outs(int'(VEC[i][32:29]), VEC[i][17:10], VEC[i][9], VEC[i][8], VEC[i][7:0]);
    end

    // R1: asynchronous reset in mid-cycle clears state at once
    op_i = 3'd1; addr_i = 8'h77;
    @(negedge clk);
    op_i = 3'd0;
    chk(2, "mem_addr_o", 32'(mem_addr_o), 32'h77);
    @(posedge clk);
    #2 rst_n = 1'b0;
    #1 chk(1, "mem_addr_o async", 32'(mem_addr_o), 32'h00);
    op_i = 3'd3; addr_i = 8'h0F;
    repeat (2) @(negedge clk);
    chk_outs(1, 8'h00, 1'b0, 1'b0, 8'h00);
    op_i = 3'd0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    op_i = 3'd6;
    @(negedge clk);
    chk_outs(1, 8'h00, 1'b0, 1'b1, 8'hFF); // R1 mask back to all ones
    op_i = 3'd0;
    @(negedge clk);
    chk(8, "rdbk_vld_o one cycle", 32'(rdbk_vld_o), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule